// File: doc/BRIEF.md
# Vectored Interrupt Controller with Atomic Enable Updates

This block collects up to 32 interrupt request lines and presents one request output to a processor. Each line is fixed at elaboration time as either edge-capturing, where a rising transition latches a status bit that stays set until software clears it, or level-following, where the status bit is set on every cycle the line is high. Software controls the block through eight 32-bit words on a simple register bus. A write takes effect on the clock edge, and a read returns data combinationally for the word that is addressed.

The enable mask can be written as a whole. It can also be changed one bit group at a time through a set-bits word and a clear-bits word, so software needs no read-modify-write sequence. Captured requests are cleared by writing ones to an acknowledge word. A vector word reports the number of the lowest-numbered source that is both captured and enabled. A two-bit master enable must read 0b11 before the request output can assert.

Top module: `ic_top`

## Requirements
- R1: After reset, the status, enable and master-enable words read zero, the vector word reads 0xFFFFFFFF, and `irqOut` is low.
- R2: Writes to each enable word act on the next clock edge:
  - A write to word 4 ORs the data into the enable mask.
  - A write to word 5 clears the enable bits that are written as one.
  - Bits written as zero to word 4 or word 5 keep their value.
  - A write to word 2 replaces the whole enable mask.
- R3: An edge source (a one in `EDGE_MASK`, default 0xFFFF0000) sets its status bit one edge after its input rises. The bit stays set after the input falls. Holding the input high after an acknowledge does not set the bit again.
- R4: A level source (a zero in `EDGE_MASK`) sets its status bit on every edge where its input is high. An acknowledge written while the input is still high leaves the bit set. Once the bit is captured, it stays set after the input falls until software acknowledges it.
- R5: Writing to word 3 clears every status bit written as one. Writing 0xFFFFFFFF clears all captured requests whose inputs are low.
- R6: Word 1 (pending) reads as the status word ANDed with the enable word.
- R7: Word 6 (vector) reads as the number of the lowest-numbered pending source. It reads 0xFFFFFFFF when nothing is pending.
- R8: Word 7 stores bits 1:0 of the written data and reads them back with the upper bits zero. `irqOut` is high exactly when some source is pending and word 7 holds 0b11.
- R9: If an input capture and an acknowledge of the same bit occur on the same edge, the status bit ends up set.
- R10: Word offsets are fixed: 0 status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master. Words 3, 4 and 5 read as zero. Writes to words 0, 1 and 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Word offset of the register access |
| busWrite | input | 1 | Write strobe, sampled on the rising clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the addressed word (combinational) |
| srcIn | input | NUM_SRC | Interrupt request inputs, one per source |
| irqOut | output | 1 | Request to the processor |

## Verification
The bench drives a level source and an edge source through the same sequence: rise, acknowledge while the input is high, fall, then acknowledge again. This sequence separates sticky capture from continuous capture and shows whether an acknowledge loses to a level that is still high. Disjoint and overlapping mask patterns written to the set and clear words show that zero bits are left alone. A pending source is combined with an enabled higher source and a captured but masked lower source, which distinguishes lowest-number priority from a plain OR or from a search over status alone. Master-enable values of 01, 10 and 11 show that both bits gate the output. A capture and an acknowledge of the same bit on one edge pins down which of the two wins.

// File: rtl/ic_pkg.sv
package ic_pkg;

  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_STATUS  = 3'd0,
    REG_PENDING = 3'd1,
    REG_ENABLE  = 3'd2,
    REG_ACK     = 3'd3,
    REG_SETEN   = 3'd4,
    REG_CLREN   = 3'd5,
    REG_VECTOR  = 3'd6,
    REG_MASTER  = 3'd7
  } regSel_e;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic    wrEnable;
    logic    setEnable;
    logic    clrEnable;
    logic    ackWrite;
    logic    wrMaster;
    regSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/ic_ctrl.sv
module ic_ctrl
  import ic_pkg::*;
(
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic                  busWrite,
  output ctrlStrobes_t          strobes
);

  regSel_e sel;

  always_comb begin
    sel                = regSel_e'(busAddr);
    strobes.rdSel      = sel;
    strobes.wrEnable   = busWrite && (sel == REG_ENABLE);
    strobes.setEnable  = busWrite && (sel == REG_SETEN);
    strobes.clrEnable  = busWrite && (sel == REG_CLREN);
    strobes.ackWrite   = busWrite && (sel == REG_ACK);
    strobes.wrMaster   = busWrite && (sel == REG_MASTER);
  end

endmodule

// File: rtl/ic_capture.sv
module ic_capture #(
  parameter int                  NUM_SRC   = 32,
  parameter logic [NUM_SRC-1:0]  EDGE_MASK = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [NUM_SRC-1:0] setVec
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : gSrc
    if (EDGE_MASK[i]) begin : gEdge
      logic prevQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) prevQ <= 1'b0;
        else       prevQ <= srcIn[i];
      end
      assign setVec[i] = srcIn[i] & ~prevQ;
    end else begin : gLevel
      assign setVec[i] = srcIn[i];
    end
  end

endmodule

// File: rtl/ic_datapath.sv
module ic_datapath
  import ic_pkg::*;
#(
  parameter int                  NUM_SRC   = 32,
  parameter int                  DATA_W    = 32,
  parameter logic [NUM_SRC-1:0]  EDGE_MASK = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqOut,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] enableQ,
  output logic [1:0]         masterQ
);

  localparam logic [DATA_W-1:0] NONE_PENDING = '1;

  logic [NUM_SRC-1:0] setVec;
  logic [NUM_SRC-1:0] wMask;
  logic [NUM_SRC-1:0] ackMask;
  logic [NUM_SRC-1:0] pendingVec;
  logic [DATA_W-1:0]  vectorVal;

  assign wMask   = busWdata[NUM_SRC-1:0];
  assign ackMask = strobes.ackWrite ? wMask : '0;

  ic_capture #(.NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK)) uCapture (
    .clk    (clk),
    .rstN   (rstN),
    .srcIn  (srcIn),
    .setVec (setVec)
  );

  // new capture takes priority over an acknowledge of the same bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~ackMask) | setVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  enableQ <= '0;
    else if (strobes.wrEnable)  enableQ <= wMask;
    else if (strobes.setEnable) enableQ <= enableQ | wMask;
    else if (strobes.clrEnable) enableQ <= enableQ & ~wMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 masterQ <= 2'b00;
    else if (strobes.wrMaster) masterQ <= busWdata[1:0];
  end

  assign pendingVec = statusQ & enableQ;
  assign irqOut     = (masterQ == 2'b11) && (|pendingVec);

  // lowest-numbered pending source wins
  always_comb begin
    vectorVal = NONE_PENDING;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendingVec[i]) vectorVal = DATA_W'(i);
    end
  end

  always_comb begin
    unique case (strobes.rdSel)
      REG_STATUS:  busRdata = DATA_W'(statusQ);
      REG_PENDING: busRdata = DATA_W'(pendingVec);
      REG_ENABLE:  busRdata = DATA_W'(enableQ);
      REG_VECTOR:  busRdata = vectorVal;
      REG_MASTER:  busRdata = DATA_W'(masterQ);
      default:     busRdata = '0;
    endcase
  end

endmodule

// File: rtl/ic_top.sv
module ic_top
  import ic_pkg::*;
#(
  parameter int                  NUM_SRC   = 32,
  parameter int                  DATA_W    = 32,
  parameter logic [NUM_SRC-1:0]  EDGE_MASK = 32'hFFFF_0000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic                  busWrite,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic [NUM_SRC-1:0]    srcIn,
  output logic                  irqOut
);

  ctrlStrobes_t       strobes;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] enableQ;
  logic [1:0]         masterQ;

  ic_ctrl uCtrl (
    .busAddr  (busAddr),
    .busWrite (busWrite),
    .strobes  (strobes)
  );

  ic_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .EDGE_MASK(EDGE_MASK)) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .busWdata (busWdata),
    .srcIn    (srcIn),
    .busRdata (busRdata),
    .irqOut   (irqOut),
    .statusQ  (statusQ),
    .enableQ  (enableQ),
    .masterQ  (masterQ)
  );

endmodule

// File: rtl/ic_checker.sv
module ic_checker #(
  parameter int                  NUM_SRC   = 32,
  parameter int                  DATA_W    = 32,
  parameter logic [NUM_SRC-1:0]  EDGE_MASK = '0
) (
  input logic               clk,
  input logic               rstN,
  input logic [2:0]         busAddr,
  input logic               busWrite,
  input logic [DATA_W-1:0]  busWdata,
  input logic [NUM_SRC-1:0] srcIn,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] statusQ,
  input logic [NUM_SRC-1:0] enableQ,
  input logic [1:0]         masterQ
);

  logic [NUM_SRC-1:0] wMask;
  assign wMask = busWdata[NUM_SRC-1:0];

  assert_set_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == 3'd4) |=> ((enableQ & $past(wMask)) == $past(wMask)));

  assert_clr_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == 3'd5) |=> ((enableQ & $past(wMask)) == '0));

  assert_master_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == 3'd7) |=> (masterQ == $past(busWdata[1:0])));

  assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (masterQ == 2'b11));

  for (genvar i = 0; i < NUM_SRC; i++) begin : gBit
    if (EDGE_MASK[i]) begin : gEdge
      assert_edge_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
        $rose(srcIn[i]) |=> statusQ[i]);
    end else begin : gLevel
      assert_level_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
        srcIn[i] |=> statusQ[i]);
    end
    assert_ack_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
      (busWrite && busAddr == 3'd3 && wMask[i] && !srcIn[i]) |=> !statusQ[i]);
  end

endmodule

bind ic_top ic_checker #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .EDGE_MASK(EDGE_MASK)) uChecker (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWrite (busWrite),
  .busWdata (busWdata),
  .srcIn    (srcIn),
  .irqOut   (irqOut),
  .statusQ  (statusQ),
  .enableQ  (enableQ),
  .masterQ  (masterQ)
);

// File: tb/tb_ic_top.sv
module tb_ic_top;

  localparam int NUM_SRC = 32;
  localparam int DATA_W  = 32;
  localparam logic [NUM_SRC-1:0] EDGE_MASK = 32'hFFFF_0000;

  localparam logic [1:0] OP_WR  = 2'd0;
  localparam logic [1:0] OP_RD  = 2'd1;
  localparam logic [1:0] OP_SRC = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VECS [NV] = '{
    '{OP_RD,  3'd0, 32'h0,         32'h0,         4'd1},  // R1 status
    '{OP_RD,  3'd2, 32'h0,         32'h0,         4'd1},  // R1 enable
    '{OP_RD,  3'd7, 32'h0,         32'h0,         4'd1},  // R1 master
    '{OP_RD,  3'd6, 32'h0,         32'hFFFF_FFFF, 4'd1},  // R1 vector
    '{OP_WR,  3'd4, 32'h0000_00F0, 32'h0,         4'd2},
    '{OP_RD,  3'd2, 32'h0,         32'h0000_00F0, 4'd2},  // R2 set
    '{OP_WR,  3'd4, 32'h0000_0003, 32'h0,         4'd2},
    '{OP_RD,  3'd2, 32'h0,         32'h0000_00F3, 4'd2},  // R2 set ORs
    '{OP_WR,  3'd5, 32'h0000_0030, 32'h0,         4'd2},
    '{OP_RD,  3'd2, 32'h0,         32'h0000_00C3, 4'd2},  // R2 clear
    '{OP_WR,  3'd2, 32'h0001_0004, 32'h0,         4'd2},
    '{OP_RD,  3'd2, 32'h0,         32'h0001_0004, 4'd2},  // R2 direct write
    '{OP_SRC, 3'd0, 32'h0000_0004, 32'h0,         4'd4},
    '{OP_RD,  3'd0, 32'h0,         32'h0000_0004, 4'd4},  // R4 level capture
    '{OP_RD,  3'd1, 32'h0,         32'h0000_0004, 4'd6},  // R6 pending
    '{OP_RD,  3'd6, 32'h0,         32'd2,         4'd7},  // R7 vector
    '{OP_WR,  3'd3, 32'h0000_0004, 32'h0,         4'd4},
    '{OP_RD,  3'd0, 32'h0,         32'h0000_0004, 4'd4},  // R4 ack while high
    '{OP_SRC, 3'd0, 32'h0,         32'h0,         4'd4},
    '{OP_RD,  3'd0, 32'h0,         32'h0000_0004, 4'd4},  // R4 held until ack
    '{OP_WR,  3'd3, 32'h0000_0004, 32'h0,         4'd5},
    '{OP_RD,  3'd0, 32'h0,         32'h0,         4'd5},  // R5 ack clears
    '{OP_SRC, 3'd0, 32'h0001_0000, 32'h0,         4'd3},
    '{OP_SRC, 3'd0, 32'h0,         32'h0,         4'd3},
    '{OP_RD,  3'd0, 32'h0,         32'h0001_0000, 4'd3},  // R3 edge sticky
    '{OP_RD,  3'd6, 32'h0,         32'd16,        4'd7},  // R7 vector 16
    '{OP_SRC, 3'd0, 32'h0000_0100, 32'h0,         4'd4},
    '{OP_RD,  3'd0, 32'h0,         32'h0001_0100, 4'd4},  // R4
    '{OP_RD,  3'd1, 32'h0,         32'h0001_0000, 4'd6},  // R6 masked bit 8
    '{OP_WR,  3'd4, 32'h0000_0100, 32'h0,         4'd2},
    '{OP_RD,  3'd6, 32'h0,         32'd8,         4'd7},  // R7 lowest wins
    '{OP_SRC, 3'd0, 32'h0,         32'h0,         4'd5},
    '{OP_WR,  3'd3, 32'hFFFF_FFFF, 32'h0,         4'd5},
    '{OP_RD,  3'd0, 32'h0,         32'h0,         4'd5},  // R5 ack all
    '{OP_RD,  3'd6, 32'h0,         32'hFFFF_FFFF, 4'd7},  // R7 none
    '{OP_WR,  3'd0, 32'hFFFF_FFFF, 32'h0,         4'd10},
    '{OP_RD,  3'd0, 32'h0,         32'h0,         4'd10}, // R10 status write ignored
    '{OP_RD,  3'd3, 32'h0,         32'h0,         4'd10}, // R10 reads zero
    '{OP_RD,  3'd4, 32'h0,         32'h0,         4'd10}, // R10
    '{OP_RD,  3'd5, 32'h0,         32'h0,         4'd10}, // R10
    '{OP_WR,  3'd7, 32'hFFFF_FFFD, 32'h0,         4'd8},
    '{OP_RD,  3'd7, 32'h0,         32'h0000_0001, 4'd8}   // R8 two bits kept
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [2:0]        busAddr = '0;
  logic              busWrite = 1'b0;
  logic [DATA_W-1:0] busWdata = '0;
  logic [DATA_W-1:0] busRdata;
  logic [NUM_SRC-1:0] srcIn = '0;
  logic              irqOut;

  int checkCount = 0;
  int failCount  = 0;

  always #5 clk = ~clk;

  ic_top #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .EDGE_MASK(EDGE_MASK)) dut (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrite (busWrite),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .srcIn    (srcIn),
    .irqOut   (irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
  endtask

  task automatic rdCheck(input string req, input logic [2:0] a, input logic [31:0] exp);
    busAddr = a;
    #1;
    check(req, busRdata, exp);
  endtask

  task automatic setSrc(input logic [31:0] v);
    @(negedge clk);
    srcIn = v;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
  endtask

  initial begin
    #(200000 * 10);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 irq after reset", {31'b0, irqOut}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      case (VECS[k].op)
        OP_WR:  wrReg(VECS[k].addr, VECS[k].data);
        OP_SRC: setSrc(VECS[k].data);
        default: rdCheck($sformatf("R%0d table row %0d", VECS[k].req, k), VECS[k].addr, VECS[k].exp);
      endcase
    end

    // R8: both master bits gate the output; enable = 0x00010104
    setSrc(32'h0000_0004);
    check("R8 master=01 irq low", {31'b0, irqOut}, 32'h0);
    wrReg(3'd7, 32'h3);
    check("R8 master=11 irq high", {31'b0, irqOut}, 32'h1);
    wrReg(3'd7, 32'h2);
    check("R8 master=10 irq low", {31'b0, irqOut}, 32'h0);
    wrReg(3'd7, 32'h3);
    wrReg(3'd5, 32'h0000_0004);
    check("R6 R8 disabled source no irq", {31'b0, irqOut}, 32'h0);
    setSrc(32'h0);
    wrReg(3'd3, 32'h0000_0004);
    rdCheck("R5 cleared after drop", 3'd0, 32'h0);

    // R3: edge held high is not captured again after an acknowledge
    setSrc(32'h0001_0000);
    wrReg(3'd3, 32'h0001_0000);
    rdCheck("R3 held edge not recaptured", 3'd0, 32'h0);
    check("R3 irq low after edge ack", {31'b0, irqOut}, 32'h0);
    setSrc(32'h0);

    // R9: capture and acknowledge of bit 17 on the same edge
    @(negedge clk);
    srcIn = 32'h0002_0000;
    busAddr = 3'd3; busWdata = 32'h0002_0000; busWrite = 1'b1;
    @(negedge clk);
    busWrite = 1'b0;
    rdCheck("R9 capture beats ack", 3'd0, 32'h0002_0000);
    setSrc(32'h0);
    wrReg(3'd3, 32'hFFFF_FFFF);

    // R10: writes to status, pending and vector have no effect
    wrReg(3'd4, 32'h0000_0008);
    setSrc(32'h0000_0008);
    wrReg(3'd0, 32'h0);
    wrReg(3'd1, 32'h0);
    wrReg(3'd6, 32'h0);
    rdCheck("R10 status unchanged", 3'd0, 32'h0000_0008);
    rdCheck("R10 vector unchanged", 3'd6, 32'd3);
    setSrc(32'h0);
    wrReg(3'd3, 32'hFFFF_FFFF);

    // R1: reset in mid-run clears all state
    wrReg(3'd4, 32'hFFFF_FFFF);
    wrReg(3'd7, 32'h3);
    setSrc(32'h0000_0020);
    check("R8 irq before reset", {31'b0, irqOut}, 32'h1);
    @(negedge clk);
    rstN = 1'b0;
    srcIn = '0;
    @(negedge clk);
    rstN = 1'b1;
    rdCheck("R1 status cleared", 3'd0, 32'h0);
    rdCheck("R1 enable cleared", 3'd2, 32'h0);
    rdCheck("R1 master cleared", 3'd7, 32'h0);
    rdCheck("R1 vector none", 3'd6, 32'hFFFF_FFFF);
    check("R1 irq low", {31'b0, irqOut}, 32'h0);

    summary();
    $finish;
  end

endmodule